// File: doc/BRIEF.md
# UART FIFO Interrupt Identification Logic

This block sits beside the receive and transmit FIFOs of a UART and turns their fill levels, the error flag of the oldest received character, an externally timed receive-idle condition and a set of enable bits into one interrupt request line and an 8-bit identification code. Software reads the code to learn the most urgent pending cause. Each cause has a fixed rank: receive line error first, receive idle timeout second, receive threshold reached third, transmit refill request last. The same block produces the three line-status flags that software polls: receive data ready, transmit data request and transmitter empty.

The transmit refill request is a latched event. It is raised when the enabled transmit FIFO drains to half its depth or less. It is dropped when software writes the transmit holding register, or when software reads the identification code while that code names the transmit request. When the FIFOs are on, DMA is off and every interrupt enable is clear, the block is in polled mode. The status flags keep updating in that mode and the interrupt line stays low. All pins are plain control and status signals with no stream handshake. Every output is registered and reflects the inputs sampled at the previous rising clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: While `fifo_en` is low, `iir_code` is 0xC1 and `irq` is low one cycle later, whatever the other inputs are.
- R2: The line-error cause (`fifo_en`, `int_en[2]`, `rx_head_err` high and `rx_level` nonzero) gives `iir_code` 0xC6. It outranks every other cause.
- R3: The idle-timeout cause (`fifo_en`, `int_en[4]`, `rx_idle_tmo` high and `rx_level` nonzero) gives 0xCC. It ranks below 0xC6 and above every other cause.
- R4: The threshold cause (`fifo_en`, `int_en[0]`, `rx_level` nonzero and `rx_level` >= `rx_trig`, with a trigger of 0 treated as 1) gives 0xC4. The code moves to the next cause as soon as the level drops below the trigger.
- R5: The transmit request is latched when `fifo_en & int_en[1] & (tx_level <= DEPTH/2)` goes from false to true. While latched and no receive cause is active, the code is 0xC2. Dropping `fifo_en` or `int_en[1]` discards the request.
- R6: A `thr_wr` pulse clears the latched transmit request. An `iir_rd` pulse clears it only while `iir_code` is 0xC2. A new rising half-empty condition in the same cycle wins over either clear.
- R7: With no cause pending, `iir_code` is 0xC1 (bit 0 high means nothing pending). `irq` is high exactly when bit 0 of `iir_code` is low. After reset, `iir_code` is 0xC1, and `irq`, `lsr_dr`, `lsr_tdrq` and `lsr_temt` are low.
- R8: `lsr_dr` is set one cycle after an `rx_push` pulse. It is cleared one cycle after `rx_level` is 0 with no push in that cycle.
- R9: `lsr_tdrq` follows `tx_level <= DEPTH/2`. `lsr_temt` follows `tx_level == 0 && tx_hold_empty`. Both have one cycle of latency and do not depend on the enables.
- R10: `polled_mode` is high one cycle after `fifo_en & ~dma_en & (int_en == 0)`. In that mode `irq` stays low while the status flags keep updating. `int_en[3]` (modem status) has no cause in this block and only affects polled-mode detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_en | input | 1 | DMA request enable |
| int_en | input | 5 | Enables: [0] rx threshold, [1] tx request, [2] line error, [3] modem, [4] idle timeout |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO fill |
| rx_trig | input | $clog2(DEPTH+1) | Receive trigger threshold |
| rx_head_err | input | 1 | Oldest receive entry has an error |
| rx_idle_tmo | input | 1 | Receive idle timeout condition from the timer |
| rx_push | input | 1 | Character moved from shifter into receive FIFO |
| tx_level | input | $clog2(DEPTH+1) | Transmit FIFO fill |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Write strobe to transmit holding register |
| iir_rd | input | 1 | Read strobe of the identification register |
| irq | output | 1 | Interrupt request |
| iir_code | output | 8 | Identification code |
| lsr_dr | output | 1 | Receive data ready |
| lsr_tdrq | output | 1 | Transmit data request |
| lsr_temt | output | 1 | Transmitter empty |
| polled_mode | output | 1 | Polled mode active |

## Verification
The hardest situation to reach is an identification read that must leave a latched transmit request in place because a higher cause hides it. The bench first latches the request by draining the transmit level through the half-depth point. It then raises a line error so the code shows 0xC6 and pulses the read strobe. After that it removes the error and expects 0xC2 to come back. The receive side is swept over every level, every trigger, the error and timeout flags and four enable patterns. A model of the rules computes the expected code at every step.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [7:0] CODE_NONE = 8'hC1;
  localparam logic [7:0] CODE_LINE = 8'hC6;
  localparam logic [7:0] CODE_TOUT = 8'hCC;
  localparam logic [7:0] CODE_RXD  = 8'hC4;
  localparam logic [7:0] CODE_TXR  = 8'hC2;

  localparam int IE_RXD   = 0;
  localparam int IE_TXR   = 1;
  localparam int IE_LINE  = 2;
  localparam int IE_MODEM = 3;
  localparam int IE_TOUT  = 4;
  localparam int IE_W     = 5;

  typedef struct packed {
    logic line;
    logic tout;
    logic rxd;
    logic txr;
  } cause_t;
endpackage

// File: rtl/uart_irq_rx_causes.sv
module uart_irq_rx_causes #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          fifo_en,
  input  logic          en_line,
  input  logic          en_tout,
  input  logic          en_rxd,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] trig,
  input  logic          head_err,
  input  logic          idle_tmo,
  output logic          line_c,
  output logic          tout_c,
  output logic          rxd_c
);
  logic [LW-1:0] eff_trig;
  logic          nonempty;

  always_comb begin
    eff_trig = (trig == '0) ? LW'(1) : trig;
    nonempty = (level != '0);
    line_c   = fifo_en && en_line && head_err && nonempty;
    tout_c   = fifo_en && en_tout && idle_tmo && nonempty;
    rxd_c    = fifo_en && en_rxd && nonempty && (level >= eff_trig);
  end
endmodule

// File: rtl/uart_irq_tx_req.sv
module uart_irq_tx_req
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] tx_level,
  input  logic          thr_wr,
  input  logic          iir_rd,
  input  logic [7:0]    code_q,
  output logic          req_next
);
  logic he, he_q, req_q;

  always_comb begin
    he       = en && (tx_level <= LW'(HALF));
    req_next = req_q;
    if (thr_wr || (iir_rd && code_q == CODE_TXR)) req_next = 1'b0;
    if (he && !he_q) req_next = 1'b1;
    if (!en) req_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      he_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      he_q  <= he;
      req_q <= req_next;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cause_t     cause,
  input  logic       quiet,
  output logic [7:0] code_q,
  output logic       irq_q
);
  logic [7:0] code_d;

  always_comb begin
    if (cause.line)      code_d = CODE_LINE;
    else if (cause.tout) code_d = CODE_TOUT;
    else if (cause.rxd)  code_d = CODE_RXD;
    else if (cause.txr)  code_d = CODE_TXR;
    else                 code_d = CODE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= CODE_NONE;
      irq_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      irq_q  <= (|cause) && !quiet;
    end
  end
endmodule

// File: rtl/uart_irq_lsr.sv
module uart_irq_lsr #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_push,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          tx_hold_empty,
  output logic          dr_q,
  output logic          tdrq_q,
  output logic          temt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_q   <= 1'b0;
      tdrq_q <= 1'b0;
      temt_q <= 1'b0;
    end else begin
      if (rx_push)              dr_q <= 1'b1;
      else if (rx_level == '0)  dr_q <= 1'b0;
      tdrq_q <= (tx_level <= LW'(HALF));
      temt_q <= (tx_level == '0) && tx_hold_empty;
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          dma_en,
  input  logic [4:0]    int_en,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] rx_trig,
  input  logic          rx_head_err,
  input  logic          rx_idle_tmo,
  input  logic          rx_push,
  input  logic [LW-1:0] tx_level,
  input  logic          tx_hold_empty,
  input  logic          thr_wr,
  input  logic          iir_rd,
  output logic          irq,
  output logic [7:0]    iir_code,
  output logic          lsr_dr,
  output logic          lsr_tdrq,
  output logic          lsr_temt,
  output logic          polled_mode
);
  cause_t cause;
  logic   polled_d, polled_q;

  assign polled_d = fifo_en && !dma_en && (int_en == '0);

  uart_irq_rx_causes #(.DEPTH(DEPTH)) u_rx (
    .fifo_en (fifo_en),
    .en_line (int_en[IE_LINE]),
    .en_tout (int_en[IE_TOUT]),
    .en_rxd  (int_en[IE_RXD]),
    .level   (rx_level),
    .trig    (rx_trig),
    .head_err(rx_head_err),
    .idle_tmo(rx_idle_tmo),
    .line_c  (cause.line),
    .tout_c  (cause.tout),
    .rxd_c   (cause.rxd)
  );

  uart_irq_tx_req #(.DEPTH(DEPTH)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (fifo_en && int_en[IE_TXR]),
    .tx_level(tx_level),
    .thr_wr  (thr_wr),
    .iir_rd  (iir_rd),
    .code_q  (iir_code),
    .req_next(cause.txr)
  );

  uart_irq_prio u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .cause (cause),
    .quiet (polled_d),
    .code_q(iir_code),
    .irq_q (irq)
  );

  uart_irq_lsr #(.DEPTH(DEPTH)) u_lsr (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_push      (rx_push),
    .rx_level     (rx_level),
    .tx_level     (tx_level),
    .tx_hold_empty(tx_hold_empty),
    .dr_q         (lsr_dr),
    .tdrq_q       (lsr_tdrq),
    .temt_q       (lsr_temt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) polled_q <= 1'b0;
    else        polled_q <= polled_d;
  end
  assign polled_mode = polled_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          dma_en,
  input logic [4:0]    int_en,
  input logic [LW-1:0] rx_level,
  input logic          rx_head_err,
  input logic          rx_push,
  input logic [LW-1:0] tx_level,
  input logic          tx_hold_empty,
  input logic          irq,
  input logic [7:0]    iir_code
);
  // R1
  fifo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (iir_code == CODE_NONE && !irq));

  // R2
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && int_en[IE_LINE] && rx_head_err && rx_level != '0) |=> iir_code == CODE_LINE);

  // R7
  irq_code_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iir_code[0]);

  // R10
  polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !dma_en && int_en == '0) |=> !irq);

  // R8
  dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> sim_dr_probe);

  // R9
  temt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0 && tx_hold_empty) |=> sim_temt_probe);

  logic sim_dr_probe, sim_temt_probe;
  assign sim_dr_probe   = uart_irq_ident.lsr_dr;
  assign sim_temt_probe = uart_irq_ident.lsr_temt;
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_en      (fifo_en),
  .dma_en       (dma_en),
  .int_en       (int_en),
  .rx_level     (rx_level),
  .rx_head_err  (rx_head_err),
  .rx_push      (rx_push),
  .tx_level     (tx_level),
  .tx_hold_empty(tx_hold_empty),
  .irq          (irq),
  .iir_code     (iir_code)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
  localparam int D  = 8;
  localparam int LW = $clog2(D + 1);
  localparam logic [7:0] C_NONE = 8'hC1, C_LINE = 8'hC6, C_TOUT = 8'hCC,
                         C_RXD = 8'hC4, C_TXR = 8'hC2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 0, dma_en = 0, rx_head_err = 0, rx_idle_tmo = 0, rx_push = 0;
  logic tx_hold_empty = 0, thr_wr = 0, iir_rd = 0;
  logic [4:0] int_en = '0;
  logic [LW-1:0] rx_level = '0, rx_trig = '0, tx_level = LW'(D);
  logic irq, lsr_dr, lsr_tdrq, lsr_temt, polled_mode;
  logic [7:0] iir_code;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_code = C_NONE;
  logic m_txr = 0, m_he = 0, m_dr = 0;

  always #5 clk = ~clk;

  uart_irq_ident #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_en(dma_en), .int_en(int_en),
    .rx_level(rx_level), .rx_trig(rx_trig), .rx_head_err(rx_head_err),
    .rx_idle_tmo(rx_idle_tmo), .rx_push(rx_push), .tx_level(tx_level),
    .tx_hold_empty(tx_hold_empty), .thr_wr(thr_wr), .iir_rd(iir_rd),
    .irq(irq), .iir_code(iir_code), .lsr_dr(lsr_dr), .lsr_tdrq(lsr_tdrq),
    .lsr_temt(lsr_temt), .polled_mode(polled_mode));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One clock of stimulus with expected values computed from the requirements.
  task automatic tick();
    logic he, txn, line, tout, rxd, pol, t_dr, t_tdrq, t_temt, clr;
    logic [LW-1:0] et;
    logic [7:0] c;
    string tag;
    he  = fifo_en && int_en[1] && (tx_level <= LW'(D/2));
    clr = thr_wr || (iir_rd && m_code == C_TXR);
    txn = m_txr;
    if (clr) txn = 0;
    if (he && !m_he) txn = 1;
    if (!(fifo_en && int_en[1])) txn = 0;
    et   = (rx_trig == '0) ? LW'(1) : rx_trig;
    line = fifo_en && int_en[2] && rx_head_err && rx_level != '0;
    tout = fifo_en && int_en[4] && rx_idle_tmo && rx_level != '0;
    rxd  = fifo_en && int_en[0] && rx_level != '0 && rx_level >= et;
    c = line ? C_LINE : tout ? C_TOUT : rxd ? C_RXD : txn ? C_TXR : C_NONE;
    pol = fifo_en && !dma_en && int_en == '0;
    t_dr = rx_push ? 1'b1 : (rx_level == '0) ? 1'b0 : m_dr;
    t_tdrq = tx_level <= LW'(D/2);
    t_temt = tx_level == '0 && tx_hold_empty;
    if (!fifo_en) tag = "R1";
    else if (thr_wr || iir_rd) tag = "R6";
    else if (c == C_LINE) tag = "R2";
    else if (c == C_TOUT) tag = "R3";
    else if (c == C_RXD) tag = "R4";
    else if (c == C_TXR) tag = "R5";
    else tag = "R7";
    m_he = he; m_txr = txn; m_code = c; m_dr = t_dr;
    @(posedge clk);
    @(negedge clk);
    check(tag, iir_code, c);
    check(pol ? "R10 irq" : "R7 irq", {7'b0, irq}, {7'b0, (c != C_NONE) && !pol});
    check("R10 polled", {7'b0, polled_mode}, {7'b0, pol});
    check("R8 dr", {7'b0, lsr_dr}, {7'b0, t_dr});
    check("R9 tdrq", {7'b0, lsr_tdrq}, {7'b0, t_tdrq});
    check("R9 temt", {7'b0, lsr_temt}, {7'b0, t_temt});
    thr_wr = 0; iir_rd = 0; rx_push = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 reset code", iir_code, C_NONE);
    check("R7 reset irq", {7'b0, irq}, 8'h00);
    check("R7 reset dr", {7'b0, lsr_dr}, 8'h00);
    check("R7 reset tdrq", {7'b0, lsr_tdrq}, 8'h00);
    rst_n = 1;
    fifo_en = 1;

    // Receive sweep (R2 R3 R4): all levels, triggers, flags, four enable sets
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: int_en = 5'b00001;
        1: int_en = 5'b00101;
        2: int_en = 5'b10101;
        default: int_en = 5'b10000;
      endcase
      for (int l = 0; l <= D; l++)
        for (int t = 0; t <= D; t++)
          for (int f = 0; f < 4; f++) begin
            rx_level = LW'(l); rx_trig = LW'(t);
            rx_head_err = f[0]; rx_idle_tmo = f[1];
            tick();
          end
    end

    // R1: FIFOs off with every cause present
    int_en = 5'b11111; rx_level = LW'(D); rx_trig = LW'(1);
    rx_head_err = 1; rx_idle_tmo = 1; fifo_en = 0; tx_level = '0;
    tick(); tick();
    fifo_en = 1; tx_level = LW'(D); rx_head_err = 0; rx_idle_tmo = 0; rx_level = '0;
    int_en = 5'b00010;
    tick();

    // R5 / R6: drain transmit through half depth, clear by THR write
    for (int l = D; l >= 0; l--) begin tx_level = LW'(l); tick(); end
    thr_wr = 1; tick(); tick();
    // refill and drain again, clear by identification read
    for (int l = 0; l <= D; l++) begin tx_level = LW'(l); tick(); end
    tx_level = LW'(D/2); tick();
    iir_rd = 1; tick(); tick();
    // R6 hidden request: read while line error masks it, request must survive
    tx_level = LW'(D); tick();
    int_en = 5'b00110; rx_level = 1; rx_head_err = 1;
    tx_level = LW'(D/2); tick();
    iir_rd = 1; tick();
    rx_head_err = 0; tick();
    check("R6 hidden request kept", iir_code, C_TXR);
    // R6 rise wins over write in the same cycle
    thr_wr = 1; tick();
    tx_level = LW'(D); tick();
    tx_level = LW'(D/2); thr_wr = 1; tick();
    check("R6 rise beats clear", iir_code, C_TXR);
    // R5 disabling discards request
    int_en = 5'b00100; tick(); int_en = 5'b00110; tick();

    // R8: data ready
    int_en = 5'b00001; rx_level = '0; rx_head_err = 0;
    rx_push = 1; tick();
    rx_level = 1; tick();
    rx_level = 2; rx_push = 1; tick();
    rx_level = '0; tick();
    rx_push = 1; tick();

    // R10: polled mode, flags still move, irq quiet
    int_en = '0; dma_en = 0;
    for (int l = 0; l <= D; l++) begin
      rx_level = LW'(l); tx_level = LW'(D - l); rx_push = l[0];
      rx_head_err = 1; tx_hold_empty = l[1]; tick();
    end
    dma_en = 1; tick();
    int_en = 5'b01000; dma_en = 0; tick();

    // R9: transmitter empty combinations
    for (int l = 0; l < 3; l++)
      for (int h = 0; h < 2; h++) begin
        tx_level = LW'(l); tx_hold_empty = h[0]; tick();
      end

    finish_run();
  end
endmodule